// File: doc/BRIEF.md
# PLL Unlock Detector with Hold-off

This block watches the two divider outputs of a PLL synthesizer, the programmable divider and the reference divider. It decides whether the loop is out of lock and drives an active-low unlock flag. It counts the system-clock cycles between a rising edge on one divider output and the matching rising edge on the other. A separation above a threshold counts as a bad phase sample. A bad sample holds the flag asserted for a fixed number of millisecond ticks, and the hold-off restarts on every later bad sample.

Two other sources force the flag. A one-cycle strobe for a new channel or a transmit/receive switch asserts it for a longer fixed number of ticks. A power-amplifier mode level asserts it for as long as the level is high. The output is a low-driving flag with a separate output enable. While the output enable is low, the pin is treated as released (open).

Top module: `pll_unlock_detect`

## Requirements
- R1: After reset the flag is released: `ul_oe` = 0 and `ul_n` = 1.
- R2: Whenever the unlock condition holds, `ul_oe` = 1 and `ul_n` = 0. Otherwise `ul_oe` = 0 and `ul_n` = 1.
- R3: The separation is counted as k cycles when the second divider edge is seen k cycles after the first edge. Edges in the same cycle give k = 0, and either divider may lead. A sample with k ≤ THRESH_CYC (default 23) does not assert the flag.
- R4: A sample with k > THRESH_CYC asserts the flag from the cycle after the second edge, whichever divider leads.
- R5: A second rising edge on the same divider before any edge on the other one is a bad sample. It asserts the flag in the next cycle and starts a new measurement from that edge.
- R6: After the last bad sample, the flag stays asserted until the HOLD_MS-th (default 6) `tick_1ms` pulse after that sample. The flag is released in the cycle after that pulse.
- R7: A bad sample while the hold-off is running reloads it to the full HOLD_MS ticks.
- R8: A `chg_strobe` pulse asserts the flag from the next cycle until the CHG_MS-th (default 25) tick after the strobe.
- R9: `pa_mode` high asserts the flag in the same cycle. Dropping it releases the flag at once when no other source is active.
- R10: A `chg_strobe` while the change timer is running reloads it to the full CHG_MS ticks.
- R11: The flag is the OR of the three sources. It is released only when all three are inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse | input | 1 | Reference divider output, synchronous to clk |
| prog_pulse | input | 1 | Programmable divider output, synchronous to clk |
| chg_strobe | input | 1 | One-cycle pulse on channel or TX/RX change |
| pa_mode | input | 1 | Power-amplifier mode level |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| ul_n | output | 1 | Unlock flag, low when asserted |
| ul_oe | output | 1 | Output enable for ul_n; low means released |

## Verification
The bench tests separations at exactly THRESH_CYC and one cycle above it, with each divider leading, and with both edges in the same cycle. A design with an off-by-one comparison flags the boundary sample wrongly or misses the first bad one. A repeated edge on the leading divider must count as bad; a design that waits forever for the other edge never flags a missing divider edge. The bench counts ticks to the exact release point for both timers and reloads each timer midway. A design that does not reload the timer releases early. The bench also drops PA mode while the change timer runs, which exposes a design that does not OR its sources.

// File: rtl/pll_unlock_detect.sv
module pll_unlock_detect #(
  parameter int THRESH_CYC = 23,
  parameter int HOLD_MS    = 6,
  parameter int CHG_MS     = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic prog_pulse,
  input  logic chg_strobe,
  input  logic pa_mode,
  input  logic tick_1ms,
  output logic ul_n,
  output logic ul_oe
);
  localparam int CW = $clog2(THRESH_CYC + 2);
  localparam int HW = $clog2(HOLD_MS + 1);
  localparam int GW = $clog2(CHG_MS + 1);
  localparam logic [CW-1:0] TH = CW'(THRESH_CYC);

  logic          ref_q, prog_q, meas, first_ref;
  logic [CW-1:0] sep;
  logic [HW-1:0] hold_cnt;
  logic [GW-1:0] chg_cnt;

  wire ref_e     = ref_pulse & ~ref_q;
  wire prog_e    = prog_pulse & ~prog_q;
  wire close_e   = meas & (first_ref ? prog_e : ref_e);
  wire repeat_e  = meas & (first_ref ? ref_e : prog_e);
  wire start_new = (~meas & (ref_e ^ prog_e)) | repeat_e;
  wire bad       = (close_e & (sep > TH)) | (repeat_e & ~close_e);
  wire unlock    = (hold_cnt != '0) | (chg_cnt != '0) | pa_mode;

  assign ul_oe = unlock;
  assign ul_n  = ~unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0; prog_q <= 1'b0;
      meas <= 1'b0; first_ref <= 1'b0; sep <= '0;
    end else begin
      ref_q  <= ref_pulse;
      prog_q <= prog_pulse;
      if (start_new) begin
        meas <= 1'b1;
        if (!meas) first_ref <= ref_e;
        sep <= CW'(1);
      end else if (close_e) begin
        meas <= 1'b0;
      end else if (meas && sep <= TH) begin
        sep <= sep + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      chg_cnt  <= '0;
    end else begin
      if (bad) hold_cnt <= HW'(HOLD_MS);
      else if (tick_1ms && hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (chg_strobe) chg_cnt <= GW'(CHG_MS);
      else if (tick_1ms && chg_cnt != '0) chg_cnt <= chg_cnt - 1'b1;
    end
  end

  // R4
  bad_sample_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !ul_n);
  // R8
  chg_asserts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_strobe |=> ul_oe);
  // R9
  pa_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pa_mode |-> (ul_oe && !ul_n));
  // R6
  hold_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt == HW'(1) && tick_1ms && !bad) |=> hold_cnt == '0);
  // R7
  hold_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= HW'(HOLD_MS));
  // R11
  release_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ul_oe) |-> (!pa_mode && !$past(chg_strobe) && !$past(bad)));
endmodule

// File: tb/pll_unlock_detect_tb.sv
module pll_unlock_detect_tb_top;
  localparam int TH = 23, HOLD = 6, CHG = 25;
  logic clk = 0, rst_n = 0;
  logic ref_pulse = 0, prog_pulse = 0, chg_strobe = 0, pa_mode = 0, tick_1ms = 0;
  logic ul_n, ul_oe;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pll_unlock_detect #(.THRESH_CYC(TH), .HOLD_MS(HOLD), .CHG_MS(CHG)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .prog_pulse(prog_pulse),
    .chg_strobe(chg_strobe), .pa_mode(pa_mode), .tick_1ms(tick_1ms),
    .ul_n(ul_n), .ul_oe(ul_oe));

  task automatic check(input string tag, input logic exp_asserted);
    n_chk++;
    if (ul_oe !== exp_asserted || ul_n !== ~exp_asserted) begin
      n_fail++;
      $display("FAIL %s: ul_oe=%b ul_n=%b expected ul_oe=%b ul_n=%b",
               tag, ul_oe, ul_n, exp_asserted, ~exp_asserted);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ref_pulse = 0; prog_pulse = 0; chg_strobe = 0; pa_mode = 0; tick_1ms = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_1ms = 1;
      @(negedge clk); tick_1ms = 0;
    end
  endtask

  // first edge, then the other edge k cycles later; returns at negedge after the second edge
  task automatic sample(input bit ref_first, input int k);
    @(negedge clk);
    if (k == 0) begin
      ref_pulse = 1; prog_pulse = 1;
      @(negedge clk); ref_pulse = 0; prog_pulse = 0;
    end else begin
      if (ref_first) ref_pulse = 1; else prog_pulse = 1;
      for (int i = 1; i <= k; i++) begin
        @(negedge clk);
        ref_pulse = 0; prog_pulse = 0;
        if (i == k) begin if (ref_first) prog_pulse = 1; else ref_pulse = 1; end
      end
      @(negedge clk); ref_pulse = 0; prog_pulse = 0;
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset released", 0);
  endtask

  task automatic t_good_samples();
    do_reset();
    sample(1, 0);  check("R3 coincident edges", 0);
    sample(1, 10); check("R3 ref leads k=10", 0);
    sample(1, TH); check("R3 ref leads k=THRESH", 0);
    sample(0, TH); check("R3 prog leads k=THRESH", 0);
    sample(0, 1);  check("R3 prog leads k=1", 0);
  endtask

  task automatic t_bad_ref_lead();
    do_reset();
    sample(1, TH + 1); check("R4 ref leads k=THRESH+1", 1);
    check("R2 encoding while asserted", 1);
  endtask

  task automatic t_bad_prog_lead_hold();
    do_reset();
    sample(0, TH + 1); check("R4 prog leads k=THRESH+1", 1);
    ticks(HOLD - 1);   check("R6 held before last tick", 1);
    ticks(1);          check("R6 released after HOLD tick", 0);
    check("R2 encoding while released", 0);
  endtask

  task automatic t_repeat_edge();
    do_reset();
    @(negedge clk); ref_pulse = 1;
    @(negedge clk); ref_pulse = 0;
    repeat (4) @(negedge clk);
    check("R5 before repeat edge", 0);
    ref_pulse = 1;
    @(negedge clk); ref_pulse = 0;
    check("R5 repeated ref edge flags", 1);
    prog_pulse = 1;
    @(negedge clk); prog_pulse = 0;
    ticks(HOLD);
    check("R5 new measurement good, hold expired", 0);
  endtask

  task automatic t_hold_restart();
    do_reset();
    sample(1, TH + 5);
    ticks(4);
    sample(0, TH + 2); check("R7 second bad sample", 1);
    ticks(HOLD - 1);   check("R7 hold reloaded", 1);
    ticks(1);          check("R7 released after full reload", 0);
  endtask

  task automatic t_change();
    do_reset();
    @(negedge clk); chg_strobe = 1;
    @(negedge clk); chg_strobe = 0;
    check("R8 strobe asserts", 1);
    ticks(CHG - 1); check("R8 held before last tick", 1);
    ticks(1);       check("R8 released after CHG tick", 0);
  endtask

  task automatic t_change_restart();
    do_reset();
    @(negedge clk); chg_strobe = 1;
    @(negedge clk); chg_strobe = 0;
    ticks(20);
    @(negedge clk); chg_strobe = 1;
    @(negedge clk); chg_strobe = 0;
    ticks(CHG - 1); check("R10 change timer reloaded", 1);
    ticks(1);       check("R10 released after reload", 0);
  endtask

  task automatic t_pa();
    do_reset();
    @(negedge clk); pa_mode = 1;
    #1 check("R9 pa asserts same cycle", 1);
    ticks(30); check("R9 pa held", 1);
    @(negedge clk); pa_mode = 0;
    #1 check("R9 pa drop releases", 0);
  endtask

  task automatic t_combine();
    do_reset();
    @(negedge clk); pa_mode = 1; chg_strobe = 1;
    @(negedge clk); chg_strobe = 0;
    ticks(3);
    @(negedge clk); pa_mode = 0;
    #1 check("R11 change timer keeps flag after pa drop", 1);
    sample(1, TH + 3);
    ticks(CHG - 4); check("R11 hold/chg still active", 0 == 1 ? 0 : 1);
    ticks(1);       check("R11 all sources clear", 0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_good_samples();
    t_bad_ref_lead();
    t_bad_prog_lead_hold();
    t_repeat_edge();
    t_hold_restart();
    t_change();
    t_change_restart();
    t_pa();
    t_combine();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule